// File: doc/BRIEF.md
# Time-Shared Multichannel Carrier NCO

This block removes the carrier from a one-bit IF sample stream for a set of satellite channels, twelve by default. It has one phase-accumulator and mixing datapath. When a sample arrives, that datapath visits the channels one after another. For each enabled channel it reads the channel's phase, frequency word, integration count and running I/Q sums from a small flop bank. It forms the sign-only I/Q product, advances the phase and writes the state back. To software the channels look parallel, but only one channel's worth of arithmetic exists.

Each product is a ±1 value in I and in Q. The block sums the products over an integration period. A global mode input chooses between a short acquisition period and a long tracking period. When a channel's period completes, its two sums are presented on a result output with a one-cycle valid pulse, and the sums restart from zero. A configuration write port loads a channel's frequency word and enable. A flag on that port optionally clears the channel's phase and integration state.

The internal clock must run at least NCH times faster than the sample strobe rate. At the default 16.368 MHz sample rate this means at least 196.4 MHz. The default periods are 1015 samples (about 62 µs) and 16368 samples (1 ms).

Top module: `carrier_nco_ts`

## Requirements
- R1: While reset is low and after reset is released, `prod_vld` and `dump_vld` are 0 and every channel is disabled, so a sample strobe produces no output until a channel is enabled.
- R2: A strobe on `smp_valid` is accepted when no sweep is running or when the running sweep is in its final slot. If it is sampled at clock edge E, enabled channel c presents its product for one cycle after edge E+c+1, so products come out in ascending channel order. A strobe at any other time during a sweep is ignored.
- R3: A channel's 32-bit phase is 0 after a write with the clear flag set. It advances by the channel's frequency word (modulo 2^32) once per accepted sample. The product for a sample uses the phase from before that sample's advance.
- R4: The quadrant is bits 31:30 of the phase. The I sign is 1 in quadrants 1 and 2, and the Q sign is 1 in quadrants 2 and 3. `prod_i` = sample XOR I sign and `prod_q` = sample XOR Q sign. A bit value of 1 means -1 and a value of 0 means +1, for samples and products alike.
- R5: Each product adds its ±1 value to the channel's I and Q sums. When a product completes the integration period, `dump_vld` pulses in the same cycle as that product. `dump_ch`, `dump_i` and `dump_q` carry the sums including that product, as two's complement values. The sums and count then restart from zero.
- R6: The period is ACQ_LEN products when `trk_mode` is 0 and TRK_LEN products when it is 1. The choice is evaluated at each product. If a channel's count already reaches the newly selected length, its next product dumps.
- R7: A disabled channel emits no product and no dump. Its phase, count and sums stay frozen, so re-enabling it without the clear flag resumes from where it stopped.
- R8: A configuration write loads the frequency word and the enable, which take effect from the next accepted sample. With `cfg_clr` at 1 the write also zeroes phase, count and sums. With `cfg_clr` at 0 it leaves them unchanged.
- R9: A configuration write whose channel index is NCH or above has no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least NCH times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new IF sample |
| smp_bit | input | 1 | One-bit IF sample (1 = -1, 0 = +1) |
| trk_mode | input | 1 | 0 selects the acquisition period, 1 the tracking period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | IDX_W | Channel index of the write |
| cfg_freq | input | PH_W | Frequency word per sample |
| cfg_en | input | 1 | Channel enable value to load |
| cfg_clr | input | 1 | Also clear phase, count and sums |
| prod_vld | output | 1 | Product valid, one cycle per channel per sample |
| prod_ch | output | IDX_W | Channel of the product |
| prod_i | output | 1 | In-phase product bit |
| prod_q | output | 1 | Quadrature product bit |
| dump_vld | output | 1 | Integration result valid |
| dump_ch | output | IDX_W | Channel of the result |
| dump_i | output | ACC_W | In-phase sum, two's complement |
| dump_q | output | ACC_W | Quadrature sum, two's complement |

## Verification
A wrong slot index or acceptance decision moves or drops a product at once, within the sweep of the sample that caused it. A corrupted phase or frequency word shows up as a wrong `prod_i`/`prod_q` bit no later than the first sample whose quadrant it changes. Errors in count or sum state stay hidden until the next dump, so the bench uses short periods, switches modes and freezes channels to bring that moment within a few samples. The reference model predicts every cycle's outputs, so an unexpected pulse is caught in the cycle it appears.

// File: rtl/cnco_pkg.sv
// Package: shared types and helpers for the time-shared carrier NCO.
// Assumes sign-bit convention: 1 means -1, 0 means +1.
package cnco_pkg;

    typedef enum logic {
        MODE_ACQ = 1'b0,
        MODE_TRK = 1'b1
    } int_mode_e;

    typedef struct packed {
        logic i_bit;
        logic q_bit;
    } iq_bits_t;

    // Sign of cosine and sine over the four quadrants, returned as {i_neg, q_neg}.
    function automatic logic [1:0] quad_signs(input logic [1:0] quad);
        logic i_neg;
        logic q_neg;
        i_neg = quad[1] ^ quad[0];
        q_neg = quad[1];
        return {i_neg, q_neg};
    endfunction

endpackage

// File: rtl/cnco_slot_seq.sv
// Module: slot sequencer. It accepts a sample strobe, holds the sample and
// walks a slot index through 0..NCH-1, one slot per clock.
// Assumes strobes are spaced at least NCH clocks apart. A strobe during a
// sweep is taken only in the final slot; otherwise it is dropped.
module cnco_slot_seq #(
    parameter int NCH   = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_bit,
    output logic             slot_act,
    output logic [IDX_W-1:0] slot_idx,
    output logic             slot_smp
);

    logic last_slot;
    logic take;

    // Final slot of a running sweep, and acceptance of a new strobe.
    always_comb begin
        last_slot = slot_act && (slot_idx == IDX_W'(NCH - 1));
        take      = smp_valid && (!slot_act || last_slot);
    end

    // Slot state: start, advance or finish a sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_act <= 1'b0;
            slot_idx <= '0;
            slot_smp <= 1'b0;
        end else if (take) begin
            slot_act <= 1'b1;
            slot_idx <= '0;
            slot_smp <= smp_bit;
        end else if (last_slot) begin
            slot_act <= 1'b0;
            slot_idx <= '0;
        end else if (slot_act) begin
            slot_idx <= slot_idx + 1'b1;
        end
    end

endmodule

// File: rtl/cnco_mix_acc.sv
// Module: the single shared datapath. From one channel's state and the
// current sample it forms the sign-only I/Q product, the advanced phase, the
// updated sums and count, and the dump decision. Purely combinational.
// Assumes cnt < len_sel on entry, or a mode change has just shortened len_sel.
module cnco_mix_acc #(
    parameter int PH_W  = 32,
    parameter int CNT_W = 14,
    parameter int ACC_W = 15
) (
    input  logic [PH_W-1:0]         phase,
    input  logic [PH_W-1:0]         freq,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic signed [ACC_W-1:0] acc_q,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [CNT_W-1:0]        len_sel,
    input  logic                    smp,
    output logic [PH_W-1:0]         phase_nxt,
    output cnco_pkg::iq_bits_t      prod,
    output logic signed [ACC_W-1:0] acc_i_nxt,
    output logic signed [ACC_W-1:0] acc_q_nxt,
    output logic [CNT_W-1:0]        cnt_nxt,
    output logic                    dump,
    output logic signed [ACC_W-1:0] sum_i,
    output logic signed [ACC_W-1:0] sum_q
);

    localparam logic signed [ACC_W-1:0] PLUS_ONE  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINUS_ONE = {ACC_W{1'b1}};

    logic [1:0]          sg;
    logic [CNT_W-1:0]    cnt_inc;

    // Mixer, phase step, integration and period test for one channel.
    always_comb begin
        sg          = cnco_pkg::quad_signs(phase[PH_W-1 -: 2]);
        prod.i_bit  = smp ^ sg[1];
        prod.q_bit  = smp ^ sg[0];
        phase_nxt   = phase + freq;
        sum_i       = acc_i + (prod.i_bit ? MINUS_ONE : PLUS_ONE);
        sum_q       = acc_q + (prod.q_bit ? MINUS_ONE : PLUS_ONE);
        cnt_inc     = cnt + CNT_W'(1);
        dump        = (cnt_inc >= len_sel);
        cnt_nxt     = dump ? '0 : cnt_inc;
        acc_i_nxt   = dump ? '0 : sum_i;
        acc_q_nxt   = dump ? '0 : sum_q;
    end

endmodule

// File: rtl/cnco_chan_bank.sv
// Module: per-channel state bank plus output registers. The bank holds
// phase, frequency, enable, count and sums for each channel in flops. The
// slot's channel is muxed into the shared datapath and its result written
// back. Configuration writes take priority over a slot update to the same
// channel. Indices at or above NCH match no channel and are ignored.
module cnco_chan_bank #(
    parameter int NCH     = 12,
    parameter int IDX_W   = 4,
    parameter int PH_W    = 32,
    parameter int CNT_W   = 14,
    parameter int ACC_W   = 15,
    parameter int ACQ_LEN = 1015,
    parameter int TRK_LEN = 16368
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_act,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic             slot_smp,
    input  logic             trk_mode,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_ch,
    input  logic [PH_W-1:0]  cfg_freq,
    input  logic             cfg_en,
    input  logic             cfg_clr,
    output logic             prod_vld,
    output logic [IDX_W-1:0] prod_ch,
    output logic             prod_i,
    output logic             prod_q,
    output logic             dump_vld,
    output logic [IDX_W-1:0] dump_ch,
    output logic [ACC_W-1:0] dump_i,
    output logic [ACC_W-1:0] dump_q
);

    logic [NCH-1:0][PH_W-1:0]  ph_arr;
    logic [NCH-1:0][PH_W-1:0]  fr_arr;
    logic [NCH-1:0][CNT_W-1:0] cnt_arr;
    logic [NCH-1:0][ACC_W-1:0] ai_arr;
    logic [NCH-1:0][ACC_W-1:0] aq_arr;
    logic [NCH-1:0]            en_arr;

    cnco_pkg::int_mode_e       mode;
    logic [CNT_W-1:0]          len_sel;
    logic                      upd;

    logic [PH_W-1:0]           ph_nxt;
    cnco_pkg::iq_bits_t        prod;
    logic signed [ACC_W-1:0]   ai_nxt;
    logic signed [ACC_W-1:0]   aq_nxt;
    logic [CNT_W-1:0]          cnt_nxt;
    logic                      dump;
    logic signed [ACC_W-1:0]   sum_i;
    logic signed [ACC_W-1:0]   sum_q;

    // Period length from the mode, and whether this slot's channel runs.
    always_comb begin
        mode    = cnco_pkg::int_mode_e'(trk_mode);
        len_sel = (mode == cnco_pkg::MODE_TRK) ? CNT_W'(TRK_LEN) : CNT_W'(ACQ_LEN);
        upd     = slot_act && en_arr[slot_idx];
    end

    cnco_mix_acc #(
        .PH_W  (PH_W),
        .CNT_W (CNT_W),
        .ACC_W (ACC_W)
    ) u_mix_acc (
        .phase     (ph_arr[slot_idx]),
        .freq      (fr_arr[slot_idx]),
        .acc_i     ($signed(ai_arr[slot_idx])),
        .acc_q     ($signed(aq_arr[slot_idx])),
        .cnt       (cnt_arr[slot_idx]),
        .len_sel   (len_sel),
        .smp       (slot_smp),
        .phase_nxt (ph_nxt),
        .prod      (prod),
        .acc_i_nxt (ai_nxt),
        .acc_q_nxt (aq_nxt),
        .cnt_nxt   (cnt_nxt),
        .dump      (dump),
        .sum_i     (sum_i),
        .sum_q     (sum_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic             cfg_hit;
        logic             slot_hit;
        logic [PH_W-1:0]  ph_r;
        logic [PH_W-1:0]  fr_r;
        logic [CNT_W-1:0] cnt_r;
        logic [ACC_W-1:0] ai_r;
        logic [ACC_W-1:0] aq_r;
        logic             en_r;

        // Address decode for this channel.
        always_comb begin
            cfg_hit  = cfg_we && (cfg_ch == IDX_W'(g));
            slot_hit = upd && (slot_idx == IDX_W'(g));
        end

        // Channel state: configuration first, then slot write-back.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ph_r  <= '0;
                fr_r  <= '0;
                cnt_r <= '0;
                ai_r  <= '0;
                aq_r  <= '0;
                en_r  <= 1'b0;
            end else if (cfg_hit) begin
                fr_r <= cfg_freq;
                en_r <= cfg_en;
                if (cfg_clr) begin
                    ph_r  <= '0;
                    cnt_r <= '0;
                    ai_r  <= '0;
                    aq_r  <= '0;
                end
            end else if (slot_hit) begin
                ph_r  <= ph_nxt;
                cnt_r <= cnt_nxt;
                ai_r  <= ai_nxt;
                aq_r  <= aq_nxt;
            end
        end

        assign ph_arr[g]  = ph_r;
        assign fr_arr[g]  = fr_r;
        assign cnt_arr[g] = cnt_r;
        assign ai_arr[g]  = ai_r;
        assign aq_arr[g]  = aq_r;
        assign en_arr[g]  = en_r;
    end

    // Registered product and dump outputs for the slot just processed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_vld <= 1'b0;
            prod_ch  <= '0;
            prod_i   <= 1'b0;
            prod_q   <= 1'b0;
            dump_vld <= 1'b0;
            dump_ch  <= '0;
            dump_i   <= '0;
            dump_q   <= '0;
        end else begin
            prod_vld <= upd;
            dump_vld <= upd && dump;
            if (upd) begin
                prod_ch <= slot_idx;
                prod_i  <= prod.i_bit;
                prod_q  <= prod.q_bit;
            end
            if (upd && dump) begin
                dump_ch <= slot_idx;
                dump_i  <= sum_i;
                dump_q  <= sum_q;
            end
        end
    end

endmodule

// File: rtl/carrier_nco_ts.sv
// Module: top of the time-shared carrier NCO. It joins the slot sequencer
// and the channel bank. Assumes the clock runs at least NCH times the sample
// strobe rate and that configuration writes avoid a running sweep when exact
// timing matters.
module carrier_nco_ts #(
    parameter int NCH     = 12,
    parameter int PH_W    = 32,
    parameter int ACQ_LEN = 1015,
    parameter int TRK_LEN = 16368,
    localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int MAX_LEN = (TRK_LEN > ACQ_LEN) ? TRK_LEN : ACQ_LEN,
    localparam int CNT_W   = $clog2(MAX_LEN + 1),
    localparam int ACC_W   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_bit,
    input  logic             trk_mode,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_ch,
    input  logic [PH_W-1:0]  cfg_freq,
    input  logic             cfg_en,
    input  logic             cfg_clr,
    output logic             prod_vld,
    output logic [IDX_W-1:0] prod_ch,
    output logic             prod_i,
    output logic             prod_q,
    output logic             dump_vld,
    output logic [IDX_W-1:0] dump_ch,
    output logic [ACC_W-1:0] dump_i,
    output logic [ACC_W-1:0] dump_q
);

    logic             slot_act;
    logic [IDX_W-1:0] slot_idx;
    logic             slot_smp;

    cnco_slot_seq #(
        .NCH   (NCH),
        .IDX_W (IDX_W)
    ) u_slot_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_bit   (smp_bit),
        .slot_act  (slot_act),
        .slot_idx  (slot_idx),
        .slot_smp  (slot_smp)
    );

    cnco_chan_bank #(
        .NCH     (NCH),
        .IDX_W   (IDX_W),
        .PH_W    (PH_W),
        .CNT_W   (CNT_W),
        .ACC_W   (ACC_W),
        .ACQ_LEN (ACQ_LEN),
        .TRK_LEN (TRK_LEN)
    ) u_chan_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_act (slot_act),
        .slot_idx (slot_idx),
        .slot_smp (slot_smp),
        .trk_mode (trk_mode),
        .cfg_we   (cfg_we),
        .cfg_ch   (cfg_ch),
        .cfg_freq (cfg_freq),
        .cfg_en   (cfg_en),
        .cfg_clr  (cfg_clr),
        .prod_vld (prod_vld),
        .prod_ch  (prod_ch),
        .prod_i   (prod_i),
        .prod_q   (prod_q),
        .dump_vld (dump_vld),
        .dump_ch  (dump_ch),
        .dump_i   (dump_i),
        .dump_q   (dump_q)
    );

endmodule

// File: rtl/cnco_chk.sv
// Module: property checker for the carrier NCO top, attached by bind.
// It watches only the top-level ports and a strobe-age counter of its own.
module cnco_chk #(
    parameter int NCH     = 12,
    parameter int IDX_W   = 4,
    parameter int ACC_W   = 15,
    parameter int MAX_LEN = 16368
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             prod_vld,
    input logic [IDX_W-1:0] prod_ch,
    input logic             dump_vld,
    input logic [IDX_W-1:0] dump_ch,
    input logic [ACC_W-1:0] dump_i,
    input logic [ACC_W-1:0] dump_q
);

    localparam int AGE_W = $clog2(NCH + 2) + 1;
    logic [AGE_W-1:0] smp_age;

    // Clocks since the last sample strobe, saturating just past NCH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_age <= AGE_W'(NCH + 1);
        end else if (smp_valid) begin
            smp_age <= '0;
        end else if (smp_age < AGE_W'(NCH + 1)) begin
            smp_age <= smp_age + 1'b1;
        end
    end

    AST_PROD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld |-> (smp_age <= AGE_W'(NCH))); // R2

    AST_CH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_vld && $past(prod_vld)) |->
        (prod_ch == (($past(prod_ch) == IDX_W'(NCH - 1)) ? IDX_W'(0) : IDX_W'($past(prod_ch) + 1'b1)))); // R2

    AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld |-> (prod_ch < IDX_W'(NCH))); // R9

    AST_DUMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        dump_vld |-> (prod_vld && (dump_ch == prod_ch))); // R5

    AST_DUMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dump_vld |-> (($signed(dump_i) <= MAX_LEN) && ($signed(dump_i) >= -MAX_LEN) &&
                      ($signed(dump_q) <= MAX_LEN) && ($signed(dump_q) >= -MAX_LEN))); // R5

endmodule

bind carrier_nco_ts cnco_chk #(
    .NCH     (NCH),
    .IDX_W   (IDX_W),
    .ACC_W   (ACC_W),
    .MAX_LEN (MAX_LEN)
) i_cnco_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .prod_vld  (prod_vld),
    .prod_ch   (prod_ch),
    .dump_vld  (dump_vld),
    .dump_ch   (dump_ch),
    .dump_i    (dump_i),
    .dump_q    (dump_q)
);

// File: tb/test_carrier_nco_ts.sv
`timescale 1ns/1ps
// Bench: behavioural reference model with an expectation queue, compared
// on every falling clock edge.
module test_carrier_nco_ts;

    localparam int NCH   = 12;
    localparam int PH_W  = 32;
    localparam int ACQ   = 4;
    localparam int TRK   = 7;
    localparam int IDX_W = 4;
    localparam int CNT_W = $clog2(((TRK > ACQ) ? TRK : ACQ) + 1);
    localparam int ACC_W = CNT_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic             smp_bit = 1'b0;
    logic             trk_mode = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_ch = '0;
    logic [PH_W-1:0]  cfg_freq = '0;
    logic             cfg_en = 1'b0;
    logic             cfg_clr = 1'b0;
    logic             prod_vld;
    logic [IDX_W-1:0] prod_ch;
    logic             prod_i;
    logic             prod_q;
    logic             dump_vld;
    logic [IDX_W-1:0] dump_ch;
    logic [ACC_W-1:0] dump_i;
    logic [ACC_W-1:0] dump_q;

    carrier_nco_ts #(
        .NCH     (NCH),
        .PH_W    (PH_W),
        .ACQ_LEN (ACQ),
        .TRK_LEN (TRK)
    ) i_carrier_nco_ts (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_bit   (smp_bit),
        .trk_mode  (trk_mode),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_freq  (cfg_freq),
        .cfg_en    (cfg_en),
        .cfg_clr   (cfg_clr),
        .prod_vld  (prod_vld),
        .prod_ch   (prod_ch),
        .prod_i    (prod_i),
        .prod_q    (prod_q),
        .dump_vld  (dump_vld),
        .dump_ch   (dump_ch),
        .dump_i    (dump_i),
        .dump_q    (dump_q)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    t;
        int    ch;
        bit    pi;
        bit    pq;
        bit    d;
        int    di;
        int    dq;
        string ptag;
        string dtag;
    } exp_t;

    exp_t        expq[$];
    bit [31:0]   m_ph[NCH];
    bit [31:0]   m_fr[NCH];
    bit          m_en[NCH];
    int          m_cnt[NCH];
    int          m_si[NCH];
    int          m_sq[NCH];
    int          cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;
    int          last_acc = -1000;
    bit          chk_on = 1'b0;
    bit          done = 1'b0;
    string       idle_tag = "R1";
    string       cur_ptag = "R3/R4";
    string       cur_dtag = "R5";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    // Per-cycle comparison of the outputs against the expectation queue.
    always @(negedge clk) begin
        exp_t e;
        int   ai;
        int   aq;
        if (chk_on) begin
            if (expq.size() > 0 && expq[0].t == cyc) begin
                e = expq.pop_front();
                check(prod_vld == 1'b1, "R2", "prod_vld", int'(prod_vld), 1);
                check(int'(prod_ch) == e.ch, "R2", "prod_ch", int'(prod_ch), e.ch);
                check(prod_i == e.pi, e.ptag, "prod_i", int'(prod_i), int'(e.pi));
                check(prod_q == e.pq, e.ptag, "prod_q", int'(prod_q), int'(e.pq));
                check(dump_vld == e.d, e.dtag, "dump_vld", int'(dump_vld), int'(e.d));
                if (e.d && dump_vld) begin
                    ai = int'($signed(dump_i));
                    aq = int'($signed(dump_q));
                    check(int'(dump_ch) == e.ch, e.dtag, "dump_ch", int'(dump_ch), e.ch);
                    check(ai == e.di, e.dtag, "dump_i", ai, e.di);
                    check(aq == e.dq, e.dtag, "dump_q", aq, e.dq);
                end
            end else begin
                check(!prod_vld && !dump_vld, idle_tag, "unexpected output",
                      int'({prod_vld, dump_vld}), 0);
            end
        end
    end

    // Configuration write, applied to the model as the requirements describe (R8, R9).
    task automatic cfg(input int ch, input bit [31:0] fr, input bit en, input bit clr);
        cfg_we   = 1'b1;
        cfg_ch   = IDX_W'(ch);
        cfg_freq = fr;
        cfg_en   = en;
        cfg_clr  = clr;
        @(negedge clk);
        cfg_we   = 1'b0;
        if (ch < NCH) begin
            m_fr[ch] = fr;
            m_en[ch] = en;
            if (clr) begin
                m_ph[ch]  = '0;
                m_cnt[ch] = 0;
                m_si[ch]  = 0;
                m_sq[ch]  = 0;
            end
        end
    endtask

    // Sample strobe; the model predicts every product and dump of the sweep.
    task automatic strobe(input bit b, input int gap);
        int m;
        m = cyc + 1;
        if (m - last_acc >= NCH) begin
            last_acc = m;
            for (int c = 0; c < NCH; c++) begin
                if (m_en[c]) begin
                    exp_t e;
                    int   quad;
                    bit   neg_i;
                    bit   neg_q;
                    int   len;
                    quad   = int'(m_ph[c][31:30]);
                    neg_i  = (quad == 1) || (quad == 2);
                    neg_q  = (quad >= 2);
                    e.t    = m + c + 1;
                    e.ch   = c;
                    e.pi   = b ^ neg_i;
                    e.pq   = b ^ neg_q;
                    m_si[c] += e.pi ? -1 : 1;
                    m_sq[c] += e.pq ? -1 : 1;
                    m_ph[c]  = m_ph[c] + m_fr[c];
                    m_cnt[c]++;
                    len    = trk_mode ? TRK : ACQ;
                    e.d    = (m_cnt[c] >= len);
                    e.di   = m_si[c];
                    e.dq   = m_sq[c];
                    e.ptag = cur_ptag;
                    e.dtag = cur_dtag;
                    if (e.d) begin
                        m_cnt[c] = 0;
                        m_si[c]  = 0;
                        m_sq[c]  = 0;
                    end
                    expq.push_back(e);
                end
            end
        end
        smp_valid = 1'b1;
        smp_bit   = b;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic settle();
        repeat (NCH + 2) @(negedge clk);
    endtask

    task automatic run_samples(input int n, input int gap, input bit [31:0] pat);
        for (int k = 0; k < n; k++) begin
            strobe(pat[k % 32], gap);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_ph[c] = '0; m_fr[c] = '0; m_en[c] = 1'b0;
            m_cnt[c] = 0; m_si[c] = 0; m_sq[c] = 0;
        end
        // R1: outputs idle while reset is held.
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check(!prod_vld && !dump_vld, "R1", "outputs in reset", int'({prod_vld, dump_vld}), 0);
            @(negedge clk);
        end
        rst_n  = 1'b1;
        chk_on = 1'b1;
        // R1: no channel enabled after reset, so a strobe gives nothing.
        idle_tag = "R1";
        run_samples(2, 14, 32'h0000_0003);
        settle();

        // R3, R4, R5: several channels with distinct frequency words.
        idle_tag = "R2";
        cfg(0,  32'h4000_0000, 1'b1, 1'b1);
        cfg(3,  32'h1000_0000, 1'b1, 1'b1);
        cfg(5,  32'hC000_0000, 1'b1, 1'b1);
        cfg(7,  32'h0000_0000, 1'b1, 1'b1);
        cfg(11, 32'h9E37_79B9, 1'b1, 1'b1);
        cfg(8,  32'h2000_0000, 1'b1, 1'b1);
        run_samples(12, 13, 32'hA5C3_96E1);

        // R2: a strobe mid-sweep is dropped, one in the final slot is taken.
        strobe(1'b1, 5);
        strobe(1'b0, 7);
        strobe(1'b1, 12);
        strobe(1'b0, 14);
        settle();

        // R6: tracking period, then back to acquisition with counts past its length.
        cur_dtag = "R6";
        trk_mode = 1'b1;
        @(negedge clk);
        run_samples(12, 12, 32'h3C5A_F00F);
        settle();
        trk_mode = 1'b0;
        @(negedge clk);
        run_samples(5, 13, 32'h0000_0015);
        settle();

        // R8: clear ch0 mid-period; keep ch5 state while changing its word.
        cur_dtag = "R8";
        cur_ptag = "R8";
        run_samples(2, 13, 32'h2);
        settle();
        cfg(0, 32'h8000_0000, 1'b1, 1'b1);
        cfg(5, 32'h0800_0000, 1'b1, 1'b0);
        run_samples(6, 13, 32'h0000_0029);
        settle();

        // R7: ch3 disabled without clear, then resumed from frozen state.
        cur_dtag = "R7";
        cur_ptag = "R7";
        idle_tag = "R7";
        cfg(3, 32'h1000_0000, 1'b0, 1'b0);
        run_samples(6, 13, 32'h0000_003A);
        settle();
        cfg(3, 32'h1000_0000, 1'b1, 1'b0);
        run_samples(6, 13, 32'h0000_0017);
        settle();

        // R9: writes to indices past the last channel change nothing.
        cur_dtag = "R9";
        cur_ptag = "R9";
        idle_tag = "R9";
        for (int ch = NCH; ch < 16; ch++) begin
            cfg(ch, 32'h4000_0000, 1'b1, 1'b1);
        end
        run_samples(8, 12, 32'h0000_00B4);
        settle();
        settle();

        check(expq.size() == 0, "R2", "pending expected products", expq.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule